// File: doc/BRIEF.md
# CPU Bus Address Decoder with Mirroring

This block sits between a 16-bit-address, 8-bit-data processor bus and four targets: a 2 KB work RAM, a window of eight peripheral registers, a general-purpose region and a program ROM. It is purely combinational. For every bus address it raises exactly one device select, and it gives each device a folded local address so that small devices appear repeated across the larger address windows they own.

The RAM occupies the lowest 8 KB of the map and repeats every 2 KB. The register window occupies the next 8 KB and repeats every 8 bytes. The region from 0x4000 to 0x7FFF passes the address through unchanged. The upper 32 KB is program ROM. A size input chooses between a 32 KB ROM, which is mapped linearly, and a 16 KB ROM, which appears twice, once in each 16 KB half.

Write strobes go only to the selected writable device. A write to the ROM reaches no device. Read data from the selected device is steered back onto a single return bus.

Top module: `cpu_bus_decode`

## Requirements
- R1: An address below 0x2000 asserts `sel_ram_o`, and `ram_addr_o` equals the address modulo 0x800.
- R2: An address from 0x2000 to 0x3FFF asserts `sel_reg_o`, and `reg_addr_o` equals the address modulo 8.
- R3: An address from 0x4000 to 0x7FFF asserts `sel_gen_o`, and `gen_addr_o` equals the address unchanged.
- R4: An address of 0x8000 or above asserts `sel_rom_o`. With `rom_32k_i`=1, `rom_addr_o` equals the address minus 0x8000.
- R5: With `rom_32k_i`=0, `rom_addr_o` equals (address − 0x8000) modulo 0x4000. Bit 14 is therefore 0, and 0xC000–0xFFFF aliases 0x8000–0xBFFF.
- R6: For every address and either ROM size, exactly one of the four selects is 1.
- R7: `ram_we_o`, `reg_we_o` and `gen_we_o` each equal `we_i` ANDed with that device's select. When the ROM is selected, all three are 0 whatever `we_i` is.
- R8: `rd_data_o` equals the read-data input of the device whose select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Bus address |
| we_i | input | 1 | Bus write strobe |
| rom_32k_i | input | 1 | ROM size: 1 = 32 KB, 0 = 16 KB mirrored |
| ram_rdata_i | input | 8 | Read data from RAM |
| reg_rdata_i | input | 8 | Read data from register window |
| gen_rdata_i | input | 8 | Read data from general region |
| rom_rdata_i | input | 8 | Read data from ROM |
| sel_ram_o | output | 1 | RAM select |
| sel_reg_o | output | 1 | Register window select |
| sel_gen_o | output | 1 | General region select |
| sel_rom_o | output | 1 | ROM select |
| ram_addr_o | output | 11 | Folded RAM address |
| reg_addr_o | output | 3 | Folded register index |
| gen_addr_o | output | 16 | Pass-through address |
| rom_addr_o | output | 15 | ROM offset |
| ram_we_o | output | 1 | RAM write enable |
| reg_we_o | output | 1 | Register write enable |
| gen_we_o | output | 1 | General region write enable |
| rd_data_o | output | 8 | Read data returned to the bus |

## Verification
The bench sweeps all 65536 addresses under both ROM sizes. This exposes any off-by-one at the region edges 0x1FFF/0x2000, 0x3FFF/0x4000 and 0x7FFF/0x8000, where a wrong compare would raise two selects or none. In 16 KB mode a design that kept address bit 14 would send 0xC000 upward to a nonexistent ROM half instead of aliasing it. A RAM or register fold with the wrong mask would break the repetition every 0x800 or every 8 bytes. The write strobe is toggled across the sweep, so a write enable leaking into the ROM region, or into an unselected device, shows up at the enable ports. Each device's read data is distinct, so a return mux that picks the wrong device is caught.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned RAM_AW = 11;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned ROM_AW = 15;
  localparam int unsigned N_RGN  = 4;

  typedef enum logic [1:0] {
    RGN_RAM = 2'd0,
    RGN_REG = 2'd1,
    RGN_GEN = 2'd2,
    RGN_ROM = 2'd3
  } region_e;
endpackage

// File: rtl/cpu_bus_region.sv
module cpu_bus_region
  import cpu_bus_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [N_RGN-1:0]  sel_o
);
  // top three address bits carve the map into 8K/8K/16K/32K pieces
  always_comb begin
    if (addr_i[ADDR_W-1])      region_o = RGN_ROM;
    else if (addr_i[ADDR_W-2]) region_o = RGN_GEN;
    else if (addr_i[ADDR_W-3]) region_o = RGN_REG;
    else                       region_o = RGN_RAM;
  end

  for (genvar g = 0; g < N_RGN; g++) begin : g_sel
    assign sel_o[g] = (region_o == region_e'(2'(g)));
  end
endmodule

// File: rtl/cpu_bus_fold.sv
module cpu_bus_fold
  import cpu_bus_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rom_32k_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [ADDR_W-1:0] gen_addr_o,
  output logic [ROM_AW-1:0] rom_addr_o
);
  assign ram_addr_o = addr_i[RAM_AW-1:0];
  assign reg_addr_o = addr_i[REG_AW-1:0];
  assign gen_addr_o = addr_i;
  // dropping bit 15 subtracts the base; half-size ROM also drops bit 14
  assign rom_addr_o = {rom_32k_i & addr_i[ROM_AW-1], addr_i[ROM_AW-2:0]};
endmodule

// File: rtl/cpu_bus_rdmux.sv
module cpu_bus_rdmux
  import cpu_bus_pkg::*;
(
  input  logic [N_RGN-1:0]             sel_i,
  input  logic [N_RGN-1:0][DATA_W-1:0] data_i,
  output logic [DATA_W-1:0]            data_o
);
  // and-or mux, relies on one-hot select
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N_RGN; i++) begin
      data_o = data_o | ({DATA_W{sel_i[i]}} & data_i[i]);
    end
  end
endmodule

// File: rtl/cpu_bus_decode.sv
module cpu_bus_decode
  import cpu_bus_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              rom_32k_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic [DATA_W-1:0] gen_rdata_i,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic              sel_ram_o,
  output logic              sel_reg_o,
  output logic              sel_gen_o,
  output logic              sel_rom_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [ADDR_W-1:0] gen_addr_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              ram_we_o,
  output logic              reg_we_o,
  output logic              gen_we_o,
  output logic [DATA_W-1:0] rd_data_o
);
  region_e                      region;
  logic [N_RGN-1:0]             sel;
  logic [N_RGN-1:0][DATA_W-1:0] rdata;

  cpu_bus_region u_region (
    .addr_i   (addr_i),
    .region_o (region),
    .sel_o    (sel)
  );

  cpu_bus_fold u_fold (
    .addr_i     (addr_i),
    .rom_32k_i  (rom_32k_i),
    .ram_addr_o (ram_addr_o),
    .reg_addr_o (reg_addr_o),
    .gen_addr_o (gen_addr_o),
    .rom_addr_o (rom_addr_o)
  );

  assign rdata[RGN_RAM] = ram_rdata_i;
  assign rdata[RGN_REG] = reg_rdata_i;
  assign rdata[RGN_GEN] = gen_rdata_i;
  assign rdata[RGN_ROM] = rom_rdata_i;

  cpu_bus_rdmux u_rdmux (
    .sel_i  (sel),
    .data_i (rdata),
    .data_o (rd_data_o)
  );

  assign sel_ram_o = sel[RGN_RAM];
  assign sel_reg_o = sel[RGN_REG];
  assign sel_gen_o = sel[RGN_GEN];
  assign sel_rom_o = sel[RGN_ROM];

  // ROM has no enable: writes there are dropped
  assign ram_we_o = we_i & sel[RGN_RAM];
  assign reg_we_o = we_i & sel[RGN_REG];
  assign gen_we_o = we_i & sel[RGN_GEN];

  logic unused_region;
  assign unused_region = ^region;
endmodule

// File: rtl/cpu_bus_decode_chk.sv
module cpu_bus_decode_chk
  import cpu_bus_pkg::*;
(
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              rom_32k_i,
  input logic [DATA_W-1:0] ram_rdata_i,
  input logic [DATA_W-1:0] rom_rdata_i,
  input logic              sel_ram_o,
  input logic              sel_reg_o,
  input logic              sel_gen_o,
  input logic              sel_rom_o,
  input logic [ROM_AW-1:0] rom_addr_o,
  input logic              ram_we_o,
  input logic              reg_we_o,
  input logic              gen_we_o,
  input logic [DATA_W-1:0] rd_data_o
);
  always_comb begin
    // R6
    one_sel_chk: assert ($countones({sel_ram_o, sel_reg_o, sel_gen_o, sel_rom_o}) == 1);
    // R7
    rom_no_we_chk: assert (!sel_rom_o || !(ram_we_o || reg_we_o || gen_we_o));
    // R7
    we_needs_strobe_chk: assert (we_i || !(ram_we_o || reg_we_o || gen_we_o));
    // R5
    rom16_fold_chk: assert (rom_32k_i || !rom_addr_o[ROM_AW-1]);
    // R4
    rom_sel_chk: assert (sel_rom_o == addr_i[ADDR_W-1]);
    // R8
    rd_ram_chk: assert (!sel_ram_o || rd_data_o == ram_rdata_i);
    // R8
    rd_rom_chk: assert (!sel_rom_o || rd_data_o == rom_rdata_i);
  end
endmodule

bind cpu_bus_decode cpu_bus_decode_chk u_chk (
  .addr_i      (addr_i),
  .we_i        (we_i),
  .rom_32k_i   (rom_32k_i),
  .ram_rdata_i (ram_rdata_i),
  .rom_rdata_i (rom_rdata_i),
  .sel_ram_o   (sel_ram_o),
  .sel_reg_o   (sel_reg_o),
  .sel_gen_o   (sel_gen_o),
  .sel_rom_o   (sel_rom_o),
  .rom_addr_o  (rom_addr_o),
  .ram_we_o    (ram_we_o),
  .reg_we_o    (reg_we_o),
  .gen_we_o    (gen_we_o),
  .rd_data_o   (rd_data_o)
);

// File: tb/cpu_bus_decode_test.sv
`timescale 1ns/1ps
module cpu_bus_decode_test;
  logic        clk = 1'b0;
  logic [15:0] addr_i = '0;
  logic        we_i = 1'b0, rom_32k_i = 1'b0;
  logic [7:0]  ram_rdata_i = '0, reg_rdata_i = '0, gen_rdata_i = '0, rom_rdata_i = '0;
  logic        sel_ram_o, sel_reg_o, sel_gen_o, sel_rom_o;
  logic [10:0] ram_addr_o;
  logic [2:0]  reg_addr_o;
  logic [15:0] gen_addr_o;
  logic [14:0] rom_addr_o;
  logic        ram_we_o, reg_we_o, gen_we_o;
  logic [7:0]  rd_data_o;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpu_bus_decode uut (.*);

  task automatic chk(string req, int act, int exp, int a);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s addr=%04h rom32=%0d actual=%0h expected=%0h", req, a, rom_32k_i, act, exp);
    end
  endtask

  initial begin
    #1;
    // address 0 after power-on: RAM selected
    chk("R1", int'(sel_ram_o), 1, 0);
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 65536; a++) begin
        int rgn, rd_exp, rom_exp;
        rom_32k_i   = s[0];
        addr_i      = 16'(a);
        we_i        = a[0] ^ a[9] ^ s[0];
        ram_rdata_i = 8'(a) ^ 8'h5a;
        reg_rdata_i = 8'(a) ^ 8'ha3;
        gen_rdata_i = 8'(a >> 8) ^ 8'h3c;
        rom_rdata_i = 8'(a >> 4) ^ 8'hc5;
        #1;
        rgn = (a < 'h2000) ? 0 : (a < 'h4000) ? 1 : (a < 'h8000) ? 2 : 3;
        // R6 exactly one select
        chk("R6", int'(sel_ram_o) + int'(sel_reg_o) + int'(sel_gen_o) + int'(sel_rom_o), 1, a);
        chk("R1", int'(sel_ram_o), int'(rgn == 0), a);
        chk("R2", int'(sel_reg_o), int'(rgn == 1), a);
        chk("R3", int'(sel_gen_o), int'(rgn == 2), a);
        chk("R4", int'(sel_rom_o), int'(rgn == 3), a);
        if (rgn == 0) chk("R1", int'(ram_addr_o), a % 'h800, a);
        if (rgn == 1) chk("R2", int'(reg_addr_o), a % 8, a);
        if (rgn == 2) chk("R3", int'(gen_addr_o), a, a);
        if (rgn == 3) begin
          rom_exp = s ? (a - 'h8000) : ((a - 'h8000) % 'h4000);
          chk(s ? "R4" : "R5", int'(rom_addr_o), rom_exp, a);
        end
        // R7 write enables
        chk("R7", int'(ram_we_o), int'(we_i && rgn == 0), a);
        chk("R7", int'(reg_we_o), int'(we_i && rgn == 1), a);
        chk("R7", int'(gen_we_o), int'(we_i && rgn == 2), a);
        // R8 read return
        rd_exp = (rgn == 0) ? int'(ram_rdata_i) : (rgn == 1) ? int'(reg_rdata_i) :
                 (rgn == 2) ? int'(gen_rdata_i) : int'(rom_rdata_i);
        chk("R8", int'(rd_data_o), rd_exp, a);
        #3;
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #2000000;
        mismatched++;
        compared++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule